// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns characters into asynchronous serial frames. A host writes a character into a single holding register; as soon as the frame engine is free, that character moves into a separate shift stage. The holding register is then free for the next character while the current one is still being sent. Every frame begins with a low start bit. The data bits follow, least-significant bit first; there are 7 or 8 of them. An even or odd parity bit is optional, and the frame ends with one or two high stop bits. The line rests at high (mark) whenever nothing is being sent.

Bit timing comes from an internal modulated divider. The base divisor sets the nominal bit length in clock cycles. An 8-bit modulation pattern then stretches selected bits of the frame by one cycle, so that a fractional division ratio can be approximated. The divider restarts at every start bit, so the pattern always lines up with the frame. Two flags show the state of the path: one says the holding register is free, and the other says the holding register and the shift stage are both idle. A synchronous soft reset aborts any activity and forces both flags high.

Top module: `uart_buf_tx`

## Requirements
- R1: When idle, txd_o is 1. After reset or soft reset, it stays 1 until the first accepted write.
- R2: A frame starts with a 0 bit, followed by the data LSB first. With len8_i=1 all 8 data bits are sent; with len8_i=0 only bits 6..0 are sent, and bit 7 is not transmitted.
- R3: With par_en_i=1, a parity bit follows the last data bit. par_odd_i=0 makes the count of ones over the sent data bits plus parity even; par_odd_i=1 makes it odd. With par_en_i=0 there is no parity bit.
- R4: The frame ends with one high stop bit when two_stop_i=0 and with two when two_stop_i=1.
- R5: Frame bit k (the start bit is k=0) lasts baud_div_i + baud_mod_i[k mod 8] clock cycles. baud_div_i must be at least 1.
- R6: buf_empty_o goes to 0 in the cycle after an accepted write. It returns to 1 in the cycle after the held character moves into the shift stage.
- R7: tx_empty_o is 1 only when the holding register is empty and no frame is in progress. It rises in the cycle after the last stop bit ends, unless another character is waiting.
- R8: If a character is waiting when the last stop bit ends, its start bit begins in the very next cycle.
- R9: A write to a full holding register replaces the waiting character. The character already being shifted is sent unchanged.
- R10: While soft_rst_i is 1, any frame is aborted, txd_o is 1, buf_empty_o and tx_empty_o are 1, tx_irq_o is 0, and writes are ignored.
- R11: tx_irq_o equals tx_ie_i AND buf_empty_o, forced to 0 during soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset, active high |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Character to send |
| len8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| two_stop_i | input | 1 | 1: two stop bits, 0: one |
| tx_ie_i | input | 1 | Buffer-free request enable |
| baud_div_i | input | 16 | Base cycles per bit |
| baud_mod_i | input | 8 | Per-bit one-cycle stretch pattern |
| txd_o | output | 1 | Serial output |
| buf_empty_o | output | 1 | Holding register free |
| tx_empty_o | output | 1 | Holding register and shift stage idle |
| tx_irq_o | output | 1 | Buffer-free request |

## Verification
A host write and the transfer from the holding register into the shift stage can happen in the same cycle. The bench provokes this in two ways. In one, it writes on two consecutive cycles from idle, so the second write meets the transfer of the first. In the other, it queues and then overwrites a character while a frame is being sent. The result is judged on the line: the first character must appear complete, and the last written character must follow with no idle cycle. The cycle-exact bit lengths are checked under sweeps of every format combination and of several divisor/pattern settings.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int FRAME_W = 12;
  localparam int LEN_W   = 4;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [LEN_W-1:0]   len;
  } frame_t;

  // LSB first: start, data, optional parity, stop(s)
  function automatic frame_t build_frame(input logic [7:0] d, input logic len8,
                                         input logic par_en, input logic par_odd,
                                         input logic two_stop);
    frame_t f;
    logic [LEN_W-1:0] pos;
    logic par;
    f.bits    = '1;
    f.bits[0] = 1'b0;
    pos = LEN_W'(1);
    for (int i = 0; i < 8; i++) begin
      if (i < 7 || len8) begin
        f.bits[pos] = d[i];
        pos = pos + LEN_W'(1);
      end
    end
    par = (^(len8 ? d : {1'b0, d[6:0]})) ^ par_odd;
    if (par_en) begin
      f.bits[pos] = par;
      pos = pos + LEN_W'(1);
    end
    f.len = pos + (two_stop ? LEN_W'(2) : LEN_W'(1));
    return f;
  endfunction
endpackage

// File: rtl/utx_baud_gen.sv
module utx_baud_gen #(
  parameter int DIV_W = 16,
  parameter int MOD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic             bit_stb_o
);
  localparam int IDX_W = (MOD_W > 1) ? $clog2(MOD_W) : 1;
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q, period;
  logic [IDX_W-1:0] idx_q, idx_nxt;

  assign period    = {1'b0, div_i} + CNT_W'(mod_i[idx_q]);
  assign bit_stb_o = run_i & (cnt_q == period - CNT_W'(1));

  generate
    if (MOD_W == (1 << IDX_W)) begin : g_pow2
      assign idx_nxt = idx_q + IDX_W'(1);
    end else begin : g_wrap
      assign idx_nxt = (idx_q == IDX_W'(MOD_W - 1)) ? '0 : idx_q + IDX_W'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (clr_i || restart_i || !run_i) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (bit_stb_o) begin
      cnt_q <= '0;
      idx_q <= idx_nxt;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/utx_holdbuf.sv
module utx_holdbuf #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          take_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (clr_i) begin
      full_o <= 1'b0;
    end else if (wr_i) begin
      // write wins over a same-cycle take: old data leaves, new data stays
      full_o <= 1'b1;
      data_o <= wr_data_i;
    end else if (take_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   load_i,
  input  frame_t frame_i,
  input  logic   bit_stb_i,
  output logic   busy_o,
  output logic   done_o,
  output logic   txd_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [LEN_W-1:0]   rem_q;

  assign done_o = busy_o & bit_stb_i & (rem_q == LEN_W'(1));
  assign txd_o  = busy_o ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      rem_q  <= '0;
      busy_o <= 1'b0;
    end else if (clr_i) begin
      sh_q   <= '1;
      rem_q  <= '0;
      busy_o <= 1'b0;
    end else if (load_i) begin
      sh_q   <= frame_i.bits;
      rem_q  <= frame_i.len;
      busy_o <= 1'b1;
    end else if (busy_o && bit_stb_i) begin
      sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
      rem_q <= rem_q - LEN_W'(1);
      if (rem_q == LEN_W'(1)) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_buf_tx.sv
module uart_buf_tx
  import utx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int MOD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             wr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             len8_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic             two_stop_i,
  input  logic             tx_ie_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic [MOD_W-1:0] baud_mod_i,
  output logic             txd_o,
  output logic             buf_empty_o,
  output logic             tx_empty_o,
  output logic             tx_irq_o
);
  logic       buf_full, busy, done, bit_stb, take;
  logic [7:0] buf_data;
  frame_t     frame;

  // transfer when idle, or exactly as the last stop bit ends
  assign take  = buf_full & (~busy | done);
  assign frame = build_frame(buf_data, len8_i, par_en_i, par_odd_i, two_stop_i);

  utx_holdbuf #(.DW(8)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (soft_rst_i),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .full_o    (buf_full),
    .data_o    (buf_data)
  );

  utx_baud_gen #(.DIV_W(DIV_W), .MOD_W(MOD_W)) u_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (soft_rst_i),
    .restart_i (take),
    .run_i     (busy),
    .div_i     (baud_div_i),
    .mod_i     (baud_mod_i),
    .bit_stb_o (bit_stb)
  );

  utx_shifter u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (soft_rst_i),
    .load_i    (take),
    .frame_i   (frame),
    .bit_stb_i (bit_stb),
    .busy_o    (busy),
    .done_o    (done),
    .txd_o     (txd_o)
  );

  assign buf_empty_o = ~buf_full;
  assign tx_empty_o  = ~buf_full & ~busy;
  assign tx_irq_o    = tx_ie_i & ~buf_full & ~soft_rst_i;
endmodule

// File: rtl/uart_buf_tx_chk.sv
module uart_buf_tx_chk #(
  parameter int DIV_W = 16,
  parameter int MOD_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             soft_rst_i,
  input logic             wr_i,
  input logic [7:0]       wr_data_i,
  input logic             len8_i,
  input logic             par_en_i,
  input logic             par_odd_i,
  input logic             two_stop_i,
  input logic             tx_ie_i,
  input logic [DIV_W-1:0] baud_div_i,
  input logic [MOD_W-1:0] baud_mod_i,
  input logic             txd_o,
  input logic             buf_empty_o,
  input logic             tx_empty_o,
  input logic             tx_irq_o
);
  // R1
  idle_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> txd_o);

  // R1
  stay_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && !wr_i) |=> tx_empty_o);

  // R6
  wr_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !soft_rst_i) |=> !buf_empty_o);

  // R7
  path_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_empty_o |-> !tx_empty_o);

  // R10
  soft_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |-> (!tx_irq_o && $past(soft_rst_i)) |-> (buf_empty_o && tx_empty_o && txd_o));

  // R11
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> (buf_empty_o && tx_ie_i));
endmodule

bind uart_buf_tx uart_buf_tx_chk #(.DIV_W(DIV_W), .MOD_W(MOD_W)) u_chk (.*);

// File: tb/uart_buf_tx_test.sv
`timescale 1ns/1ps
module uart_buf_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic        len8 = 1'b1, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic        tx_ie = 1'b0;
  logic [15:0] bdiv = 16'd2;
  logic [7:0]  bmod = 8'hB4;
  logic        txd, buf_empty, tx_empty, tx_irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_buf_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .wr_i(wr), .wr_data_i(wdata),
    .len8_i(len8), .par_en_i(par_en), .par_odd_i(par_odd), .two_stop_i(two_stop),
    .tx_ie_i(tx_ie), .baud_div_i(bdiv), .baud_mod_i(bmod),
    .txd_o(txd), .buf_empty_o(buf_empty), .tx_empty_o(tx_empty), .tx_irq_o(tx_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  function automatic int bit_len(input int k);
    return int'(bdiv) + ((int'(bmod) >> (k % 8)) & 1);
  endfunction

  // expected frame computed arithmetically; now=1 demands start in the first cycle
  task automatic check_frame(input logic [7:0] d, input bit now);
    int nd, nb, dm, val, low, bad, wt;
    bit p;
    nd  = len8 ? 8 : 7;
    dm  = int'(d) & ((1 << nd) - 1);
    p   = ($countones(dm) % 2 == 1) ^ par_odd;
    nb  = 1 + nd + int'(par_en) + 1 + int'(two_stop);
    low = nd + 1 + int'(par_en);
    val = (dm << 1) | ((par_en && p) ? (1 << (nd + 1)) : 0);
    val = val | (((1 << nb) - 1) & ~((1 << low) - 1));
    wt = 0;
    forever begin
      @(negedge clk);
      if (txd == 1'b0) break;
      wt++;
      if (now || wt > 4000) break;
    end
    if (now) chk(wt == 0, "R8 no gap before next start", wt, 0);
    if (txd != 1'b0) begin
      chk(0, "R2 start bit not seen", int'(txd), 0);
      return;
    end
    for (int k = 0; k < nb; k++) begin
      bad = 0;
      for (int c = 0; c < bit_len(k); c++) begin
        if (k > 0 || c > 0) @(negedge clk);
        if (txd != ((val >> k) & 1)) bad++;
      end
      if (k <= nd)
        chk(bad == 0, "R2/R5 start or data bit", bad, 0);
      else if (par_en && k == nd + 1)
        chk(bad == 0, "R3/R5 parity bit", bad, 0);
      else
        chk(bad == 0, "R4/R5 stop bit", bad, 0);
    end
  endtask

  task automatic xmit(input logic [7:0] d);
    fork
      check_frame(d, 0);
      write(d);
    join
    @(negedge clk);
    chk(tx_empty == 1'b1, "R7 empty after last stop", int'(tx_empty), 1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int idle_bad;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R6 R7 R11 reset state
    chk(txd == 1'b1, "R1 idle mark after reset", int'(txd), 1);
    chk(buf_empty == 1'b1, "R6 buffer empty after reset", int'(buf_empty), 1);
    chk(tx_empty == 1'b1, "R7 path empty after reset", int'(tx_empty), 1);
    chk(tx_irq == 1'b0, "R11 request off with enable low", int'(tx_irq), 0);
    tx_ie = 1'b1;
    @(negedge clk);
    chk(tx_irq == 1'b1, "R11 request on when free", int'(tx_irq), 1);

    // R6 R11 flag sequence around one write
    fork
      check_frame(8'h5A, 0);
      begin
        write(8'h5A);
        chk(buf_empty == 1'b0, "R6 cleared by write", int'(buf_empty), 0);
        chk(tx_irq == 1'b0, "R11 request off while full", int'(tx_irq), 0);
        @(negedge clk);
        chk(buf_empty == 1'b1, "R6 set after transfer", int'(buf_empty), 1);
        chk(tx_empty == 1'b0, "R7 busy while shifting", int'(tx_empty), 0);
      end
    join
    @(negedge clk);
    chk(tx_empty == 1'b1, "R7 empty after frame", int'(tx_empty), 1);

    // format and timing sweep
    for (int b = 0; b < 3; b++) begin
      case (b)
        0: begin bdiv = 16'd2; bmod = 8'hB4; end
        1: begin bdiv = 16'd3; bmod = 8'h6D; end
        default: begin bdiv = 16'd1; bmod = 8'h01; end
      endcase
      for (int cfg = 0; cfg < 16; cfg++) begin
        {two_stop, par_odd, par_en, len8} = 4'(cfg);
        if (cfg == 15 && b == 0) begin
          for (int v = 0; v < 256; v++) xmit(8'(v));
        end else begin
          for (int v = 0; v < 8; v++) xmit(8'(v * 37 + cfg * 11 + 128 * (v % 2)));
        end
      end
    end

    // same-cycle write and transfer from idle: R8
    bdiv = 16'd2; bmod = 8'hB4; len8 = 1; par_en = 1; par_odd = 0; two_stop = 0;
    fork
      check_frame(8'hC3, 0);
      begin
        @(negedge clk); wr = 1'b1; wdata = 8'hC3;
        @(negedge clk); wdata = 8'h3C;
        @(negedge clk); wr = 1'b0;
        chk(buf_empty == 1'b0, "R6 second char queued", int'(buf_empty), 0);
      end
    join
    check_frame(8'h3C, 1);
    @(negedge clk);
    chk(tx_empty == 1'b1, "R7 empty after pair", int'(tx_empty), 1);

    // overwrite of pending character: R9
    fork
      check_frame(8'hA1, 0);
      begin
        write(8'hA1);
        write(8'hB2);
        write(8'hE7);
        chk(buf_empty == 1'b0, "R9 still one pending", int'(buf_empty), 0);
      end
    join
    check_frame(8'hE7, 1);
    @(negedge clk);
    chk(tx_empty == 1'b1, "R9 no third frame", int'(tx_empty), 1);

    // soft reset mid-frame: R10
    write(8'h00);
    repeat (5) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R10 line mark in soft reset", int'(txd), 1);
    chk(buf_empty == 1'b1, "R10 buffer flag held", int'(buf_empty), 1);
    chk(tx_empty == 1'b1, "R10 path flag held", int'(tx_empty), 1);
    chk(tx_irq == 1'b0, "R10 request held off", int'(tx_irq), 0);
    wr = 1'b1; wdata = 8'h0F;
    @(negedge clk);
    wr = 1'b0;
    chk(buf_empty == 1'b1, "R10 write ignored", int'(buf_empty), 1);
    soft_rst = 1'b0;
    idle_bad = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (txd != 1'b1 || tx_empty != 1'b1) idle_bad++;
    end
    chk(idle_bad == 0, "R1 stays mark after soft reset", idle_bad, 0);
    chk(tx_irq == 1'b1, "R11 request back after soft reset", int'(tx_irq), 1);
    d = 8'h96;
    xmit(d);

    finished = 1;
    summary();
    $finish;
  end
endmodule